// File: doc/BRIEF.md
# Paired-Single Lane Shuffle Unit

This block is the lane-movement datapath of a floating-point unit that handles a paired-single format. Such a value is 64 bits wide and holds two single-precision numbers. The upper single sits in bits [63:32] and the lower single in bits [31:0]. Each single is one sign bit, then eight exponent bits, then twenty-three fraction bits. The unit never looks inside a single. It only moves whole 32-bit lanes, so it never rounds and never raises an arithmetic exception.

The issue stage presents two 64-bit sources, a 6-bit function code, a 5-bit format field, the low bits of the general register that holds the align offset, and a core-endianness strap. One clock later the unit returns a 64-bit result together with a valid flag and an unpredictable flag. It supports the following operations:

- the four pair-pick shuffles;
- the variable align, whose lane choice depends on endianness;
- packing two singles into one pair;
- extracting either half of a pair as a single.

Any other code or format leaves the result register unchanged and drops valid.

Top module: `pspu_permute`

## Requirements
- R1: A synchronous active-high reset clears `result_o`, `valid_o` and `unpred_o` to zero on the next clock edge.
- R2: With format 5'b10110 (paired-single), function 6'b101100 gives {fs[31:0], ft[31:0]}, 6'b101101 gives {fs[31:0], ft[63:32]}, 6'b101110 gives {fs[63:32], ft[31:0]} and 6'b101111 gives {fs[63:32], ft[63:32]}. In each case the first named lane lands in bits [63:32].
- R3: With format 5'b10000 (single), function 6'b100110 packs the sources as {fs[31:0], ft[31:0]}.
- R4: With the paired-single format, function 6'b101000 returns {32'h0, fs[31:0]} and function 6'b100000 returns {32'h0, fs[63:32]}. The single result is placed in the low half, and the high half is zero.
- R5: Function 6'b100000 with any format other than paired-single is a generic convert, which this unit does not implement. Valid drops, and the result holds its previous value.
- R6: The align is function 6'b011110 with the paired-single format. When offset bit 2 is clear, the result is fs unchanged.
- R7: For the align with offset bit 2 set, a big-endian core (strap 1) gets {fs[31:0], ft[63:32]} and a little-endian core (strap 0) gets {ft[31:0], fs[63:32]}.
- R8: `unpred_o` is 1 exactly when a valid align had a nonzero offset[1:0]. The result is still formed as in R6 and R7.
- R9: Any function and format pair not listed in R2 to R7 gives `valid_o` 0 and `unpred_o` 0, and `result_o` keeps its previous value.
- R10: Each output reflects the inputs sampled at the preceding clock edge, which is exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| func_i | input | 6 | Function code |
| fmt_i | input | 5 | Format field |
| fs_i | input | 64 | First source operand |
| ft_i | input | 64 | Second source operand |
| off_i | input | OFF_W (3) | Low bits of the general register holding the align offset |
| big_endian_i | input | 1 | Core endianness strap, 1 = big-endian |
| result_o | output | 64 | Registered result |
| valid_o | output | 1 | Previous cycle held a recognised operation |
| unpred_o | output | 1 | Previous cycle was an align with a misaligned offset |

## Verification
The hardest case to reach is the hold behaviour after an illegal code that follows a legal one. The check needs a result register already loaded with a value distinct from zero and from the new operands. The bench therefore interleaves illegal codes, including function 6'b100000 under the single format, directly after picks with unique lane patterns. It then compares the held value. The align is driven with every offset[2:0] value under both straps, so the lane swap and the unpredictable flag are each seen in isolation. A long random stream then mixes legal and illegal pairs against the behavioural model.

// File: rtl/pspu_pkg.sv
package pspu_pkg;
    localparam logic [4:0] FMT_PAIR   = 5'b10110;
    localparam logic [4:0] FMT_SINGLE = 5'b10000;

    localparam logic [5:0] FN_PICK_LL = 6'b101100;
    localparam logic [5:0] FN_PICK_LU = 6'b101101;
    localparam logic [5:0] FN_PICK_UL = 6'b101110;
    localparam logic [5:0] FN_PICK_UU = 6'b101111;
    localparam logic [5:0] FN_PACK    = 6'b100110;
    localparam logic [5:0] FN_XT_LO   = 6'b101000;
    localparam logic [5:0] FN_XT_UP   = 6'b100000;
    localparam logic [5:0] FN_ALIGN   = 6'b011110;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_PICK_LL,
        OP_PICK_LU,
        OP_PICK_UL,
        OP_PICK_UU,
        OP_PACK,
        OP_XT_LO,
        OP_XT_UP,
        OP_ALIGN
    } pspu_op_e;
endpackage

// File: rtl/pspu_decode.sv
module pspu_decode
    import pspu_pkg::*;
(
    input  logic [5:0] func_i,
    input  logic [4:0] fmt_i,
    output pspu_op_e   op_o
);
    always_comb begin
        op_o = OP_NONE;
        if (fmt_i == FMT_PAIR) begin
            case (func_i)
                FN_PICK_LL: op_o = OP_PICK_LL;
                FN_PICK_LU: op_o = OP_PICK_LU;
                FN_PICK_UL: op_o = OP_PICK_UL;
                FN_PICK_UU: op_o = OP_PICK_UU;
                FN_XT_LO:   op_o = OP_XT_LO;
                FN_XT_UP:   op_o = OP_XT_UP;
                FN_ALIGN:   op_o = OP_ALIGN;
                default:    op_o = OP_NONE;
            endcase
        end else if (fmt_i == FMT_SINGLE && func_i == FN_PACK) begin
            op_o = OP_PACK;
        end
    end
endmodule

// File: rtl/pspu_lane_mux.sv
module pspu_lane_mux
    import pspu_pkg::*;
#(
    parameter int unsigned LANE_W = 32,
    parameter int unsigned OFF_W  = 3,
    localparam int unsigned DATA_W = 2 * LANE_W
) (
    input  pspu_op_e           op_i,
    input  logic [DATA_W-1:0]  fs_i,
    input  logic [DATA_W-1:0]  ft_i,
    input  logic [OFF_W-1:0]   off_i,
    input  logic               big_endian_i,
    output logic [DATA_W-1:0]  res_o,
    output logic               legal_o,
    output logic               unpred_o
);
    logic [LANE_W-1:0] fs_hi, fs_lo, ft_hi, ft_lo;
    logic [LANE_W-1:0] al_hi, al_lo;

    assign fs_hi = fs_i[DATA_W-1:LANE_W];
    assign fs_lo = fs_i[LANE_W-1:0];
    assign ft_hi = ft_i[DATA_W-1:LANE_W];
    assign ft_lo = ft_i[LANE_W-1:0];

    // Align lane choice: offset bit 2 enables the shift, strap picks source order
    always_comb begin
        if (!off_i[2]) begin
            al_hi = fs_hi;
            al_lo = fs_lo;
        end else if (big_endian_i) begin
            al_hi = fs_lo;
            al_lo = ft_hi;
        end else begin
            al_hi = ft_lo;
            al_lo = fs_hi;
        end
    end

    always_comb begin
        res_o    = '0;
        legal_o  = 1'b1;
        unpred_o = 1'b0;
        unique case (op_i)
            OP_PICK_LL: res_o = {fs_lo, ft_lo};
            OP_PICK_LU: res_o = {fs_lo, ft_hi};
            OP_PICK_UL: res_o = {fs_hi, ft_lo};
            OP_PICK_UU: res_o = {fs_hi, ft_hi};
            OP_PACK:    res_o = {fs_lo, ft_lo};
            OP_XT_LO:   res_o = {{LANE_W{1'b0}}, fs_lo};
            OP_XT_UP:   res_o = {{LANE_W{1'b0}}, fs_hi};
            OP_ALIGN: begin
                res_o    = {al_hi, al_lo};
                unpred_o = |off_i[1:0];
            end
            OP_NONE:    legal_o = 1'b0;
            default:    legal_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pspu_permute.sv
module pspu_permute
    import pspu_pkg::*;
#(
    parameter int unsigned LANE_W = 32,
    parameter int unsigned OFF_W  = 3,
    localparam int unsigned DATA_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [5:0]        func_i,
    input  logic [4:0]        fmt_i,
    input  logic [DATA_W-1:0] fs_i,
    input  logic [DATA_W-1:0] ft_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic              big_endian_i,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o,
    output logic              unpred_o
);
    pspu_op_e          op_n;
    logic [DATA_W-1:0] res_n;
    logic              legal_n;
    logic              unp_n;

    logic [DATA_W-1:0] res_q;
    logic              vld_q;
    logic              unp_q;

    pspu_decode u_dec (
        .func_i (func_i),
        .fmt_i  (fmt_i),
        .op_o   (op_n)
    );

    pspu_lane_mux #(.LANE_W(LANE_W), .OFF_W(OFF_W)) u_mux (
        .op_i         (op_n),
        .fs_i         (fs_i),
        .ft_i         (ft_i),
        .off_i        (off_i),
        .big_endian_i (big_endian_i),
        .res_o        (res_n),
        .legal_o      (legal_n),
        .unpred_o     (unp_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            vld_q <= 1'b0;
            unp_q <= 1'b0;
        end else begin
            vld_q <= legal_n;
            unp_q <= legal_n & unp_n;
            if (legal_n) begin
                res_q <= res_n;
            end
        end
    end

    assign result_o = res_q;
    assign valid_o  = vld_q;
    assign unpred_o = unp_q;
endmodule

// File: rtl/pspu_checker.sv
module pspu_checker
    import pspu_pkg::*;
#(
    parameter int unsigned LANE_W = 32,
    parameter int unsigned OFF_W  = 3,
    localparam int unsigned DATA_W = 2 * LANE_W
) (
    input logic              clk,
    input logic              rst,
    input logic [5:0]        func_i,
    input logic [4:0]        fmt_i,
    input logic [DATA_W-1:0] fs_i,
    input logic [DATA_W-1:0] ft_i,
    input logic [OFF_W-1:0]  off_i,
    input logic              big_endian_i,
    input logic [DATA_W-1:0] result_o,
    input logic              valid_o,
    input logic              unpred_o
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (result_o == '0 && !valid_o && !unpred_o)); // R1

    AST_PICK_LU: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fmt_i) == FMT_PAIR && $past(func_i) == FN_PICK_LU)
        |-> (valid_o && result_o == {$past(fs_i[LANE_W-1:0]), $past(ft_i[DATA_W-1:LANE_W])})); // R2

    AST_EXTRACT_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fmt_i) == FMT_PAIR &&
         ($past(func_i) == FN_XT_LO || $past(func_i) == FN_XT_UP))
        |-> (valid_o && result_o[DATA_W-1:LANE_W] == '0)); // R4

    AST_ALIGN_PASS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fmt_i) == FMT_PAIR && $past(func_i) == FN_ALIGN && !$past(off_i[2]))
        |-> (result_o == $past(fs_i))); // R6

    AST_ALIGN_BIG: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fmt_i) == FMT_PAIR && $past(func_i) == FN_ALIGN &&
         $past(off_i[2]) && $past(big_endian_i))
        |-> (result_o == {$past(fs_i[LANE_W-1:0]), $past(ft_i[DATA_W-1:LANE_W])})); // R7

    AST_UNPRED_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        unpred_o |-> valid_o); // R8

    AST_HOLD_WHEN_INVALID: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !valid_o) |-> ($stable(result_o) && !unpred_o)); // R9
endmodule

bind pspu_permute pspu_checker #(.LANE_W(LANE_W), .OFF_W(OFF_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .func_i       (func_i),
    .fmt_i        (fmt_i),
    .fs_i         (fs_i),
    .ft_i         (ft_i),
    .off_i        (off_i),
    .big_endian_i (big_endian_i),
    .result_o     (result_o),
    .valid_o      (valid_o),
    .unpred_o     (unpred_o)
);

// File: tb/tb_pspu_permute.sv
module tb_pspu_permute;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  func = '0;
    logic [4:0]  fmt = '0;
    logic [63:0] fs = '0;
    logic [63:0] ft = '0;
    logic [2:0]  off = '0;
    logic        be = 1'b0;
    logic [63:0] result;
    logic        valid;
    logic        unpred;

    int n_vec = 0;
    int n_bad = 0;

    logic [63:0] m_res = '0;
    logic        m_vld = 1'b0;
    logic        m_unp = 1'b0;

    always #10 clk = ~clk;

    pspu_permute dut (
        .clk(clk), .rst(rst), .func_i(func), .fmt_i(fmt), .fs_i(fs), .ft_i(ft),
        .off_i(off), .big_endian_i(be), .result_o(result), .valid_o(valid), .unpred_o(unpred)
    );

    // Behavioural reference: advance the model state for one clock
    task automatic model_step();
        logic [31:0] sh, sl, th, tl;
        logic        ok;
        logic [63:0] r;
        logic        u;
        sh = fs[63:32]; sl = fs[31:0]; th = ft[63:32]; tl = ft[31:0];
        ok = 1'b1; r = 64'h0; u = 1'b0;
        if (fmt == 5'b10110 && func == 6'b101100)      r = {sl, tl};
        else if (fmt == 5'b10110 && func == 6'b101101) r = {sl, th};
        else if (fmt == 5'b10110 && func == 6'b101110) r = {sh, tl};
        else if (fmt == 5'b10110 && func == 6'b101111) r = {sh, th};
        else if (fmt == 5'b10000 && func == 6'b100110) r = {sl, tl};
        else if (fmt == 5'b10110 && func == 6'b101000) r = {32'h0, sl};
        else if (fmt == 5'b10110 && func == 6'b100000) r = {32'h0, sh};
        else if (fmt == 5'b10110 && func == 6'b011110) begin
            u = (off[1:0] != 2'b00);
            if (off[2] == 1'b0) r = fs;
            else if (be)       r = {sl, th};
            else               r = {tl, sh};
        end else ok = 1'b0;
        if (rst) begin
            m_res = '0; m_vld = 1'b0; m_unp = 1'b0;
        end else begin
            m_vld = ok;
            m_unp = ok & u;
            if (ok) m_res = r;
        end
    endtask

    task automatic compare(input string tag);
        n_vec++;
        if (result !== m_res || valid !== m_vld || unpred !== m_unp) begin
            n_bad++;
            $display("FAIL %s: got res=%h v=%b u=%b expected res=%h v=%b u=%b",
                     tag, result, valid, unpred, m_res, m_vld, m_unp);
        end
    endtask

    // Called at a falling edge: drive, let one rising edge pass, compare at the next falling edge
    task automatic apply(input logic [5:0] f, input logic [4:0] m, input logic [63:0] a,
                         input logic [63:0] b, input logic [2:0] o, input logic e, input string tag);
        func = f; fmt = m; fs = a; ft = b; off = o; be = e;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hung expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    localparam logic [63:0] A = 64'hA1A2A3A4_B1B2B3B4;
    localparam logic [63:0] B = 64'hC1C2C3C4_D1D2D3D4;

    initial begin
        @(negedge clk);
        apply(6'b101111, 5'b10110, A, B, 3'd0, 1'b0, "R1 reset");
        apply(6'b101100, 5'b10110, A, B, 3'd0, 1'b0, "R1 reset");
        rst = 1'b0;
        apply(6'b101100, 5'b10110, A, B, 3'd0, 1'b0, "R2 pick LL");
        apply(6'b101101, 5'b10110, A, B, 3'd0, 1'b0, "R2 pick LU");
        apply(6'b101110, 5'b10110, A, B, 3'd0, 1'b0, "R2 pick UL");
        apply(6'b101111, 5'b10110, A, B, 3'd0, 1'b0, "R2 pick UU");
        apply(6'b100110, 5'b10000, A, B, 3'd0, 1'b0, "R3 pack");
        apply(6'b100110, 5'b10110, B, A, 3'd0, 1'b0, "R9 pack under pair format");
        apply(6'b101000, 5'b10110, A, B, 3'd0, 1'b0, "R4 extract lower");
        apply(6'b100000, 5'b10110, A, B, 3'd0, 1'b0, "R4 extract upper");
        apply(6'b101111, 5'b10110, B, A, 3'd0, 1'b0, "R10 load");
        apply(6'b100000, 5'b10000, A, B, 3'd0, 1'b0, "R5 convert not decoded");
        apply(6'b100000, 5'b10001, A, B, 3'd0, 1'b0, "R5 convert other format");
        for (int o = 0; o < 8; o++) begin
            apply(6'b011110, 5'b10110, A, B, o[2:0], 1'b1, "R6 R7 R8 align big");
            apply(6'b011110, 5'b10110, B, A, o[2:0], 1'b0, "R6 R7 R8 align little");
        end
        apply(6'b111111, 5'b10110, A, B, 3'd1, 1'b0, "R9 illegal func");
        apply(6'b011110, 5'b10000, A, B, 3'd5, 1'b1, "R9 align wrong format");
        for (int i = 0; i < 400; i++) begin
            logic [5:0] f;
            logic [4:0] m;
            case ($urandom_range(0, 9))
                0: f = 6'b101100; 1: f = 6'b101101; 2: f = 6'b101110; 3: f = 6'b101111;
                4: f = 6'b100110; 5: f = 6'b101000; 6: f = 6'b100000; 7: f = 6'b011110;
                default: f = 6'($urandom);
            endcase
            case ($urandom_range(0, 3))
                0, 1: m = 5'b10110;
                2: m = 5'b10000;
                default: m = 5'($urandom);
            endcase
            if ($urandom_range(0, 19) == 0) rst = 1'b1; else rst = 1'b0;
            apply(f, m, {$urandom, $urandom}, {$urandom, $urandom}, 3'($urandom),
                  1'($urandom), "R10 random stream");
        end
        rst = 1'b0;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule